// File: doc/BRIEF.md
# Move-Arithmetic Fusion Unit

This unit sits in the decode stage and watches a stream of decoded instruction records. A register-to-register move copies its source into a destination register. When the very next instruction is a two-operand arithmetic operation that writes that same destination, the unit merges the two into one three-operand operation. The fused operation reads the move's source where the arithmetic would have read the destination. It writes the shared destination and leaves one issue slot, so the pair completes in one cycle instead of two.

Records enter on a valid/ready handshake and leave as issue records on a second handshake. Each issue record is either a fused pair or one instruction passed through unchanged. A fused record carries a flag and both original instruction addresses, so exception and trace logic can still attribute it. A move is kept back for one cycle to meet a possible partner. A flush input drops any held move.

Kind codes on `in_kind` and `out_kind`: 0 = other, 1 = move, 2 = two-operand arithmetic (`rd = rd op rs`), 3 = fused three-operand (output only). A move means `rd = rs`.

Top module: `mov_alu_fuse`

## Requirements
- R1: After reset, with no input offered, `out_valid` is low.
- R2: With no move held, a valid record of kind 0 or 2 leaves in the same cycle with `in_ready = out_ready`. The output record has the same kind and function, `out_srca = in_rd`, `out_srcb = in_rs`, `out_dst = in_rd`, `out_pc = out_pc2 = in_pc` and `out_fused = 0`.
- R3: A move accepted while no move is held produces no output in the cycle it is accepted. In the following cycle (no flush) an output record is valid.
- R4: A held move fuses with the next valid input only when that input has kind 2 and its `in_rd` equals the move's destination. The pair then leaves as one record, and the arithmetic input is consumed in the same handshake.
- R5: A fused record has `out_srca` = move source and `out_dst` = move destination, and takes its function from the arithmetic. `out_srcb` is the arithmetic's `in_rs`, replaced by the move source when that `in_rs` equals the move destination.
- R6: A fused record has `out_kind = 3`, `out_fused = 1`, `out_pc` = move address and `out_pc2` = arithmetic address.
- R7: When the held move does not fuse with a valid successor, the move leaves alone with kind 1, `out_srca = out_dst` = its destination, `out_srcb` = its source and `out_fused = 0`. The successor is not consumed in that cycle unless it is itself a move. The successor then leaves later in program order.
- R8: A held move whose successor is not valid in the cycle after its capture leaves alone in that cycle. Nothing further is issued while the input stays idle.
- R9: While `flush` is high, `out_valid` is low and `in_ready` is high (the offered input is dropped). A move held at that time is discarded and never issued.
- R10: While `out_ready` is low, a valid output record stays valid, and no kind 0 or 2 input is consumed. Every instruction is issued exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard held and offered instructions |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted when high with in_valid |
| in_kind | input | 2 | Input kind code |
| in_func | input | FW (4) | Arithmetic function code |
| in_rs | input | RW (5) | Source register (move source or arithmetic second source) |
| in_rd | input | RW (5) | Destination register (also the arithmetic first source) |
| in_pc | input | AW (32) | Instruction address |
| out_valid | output | 1 | Issue record valid |
| out_ready | input | 1 | Downstream accepts issue record |
| out_kind | output | 2 | Issue kind code |
| out_func | output | FW (4) | Function code |
| out_srca | output | RW (5) | First source register |
| out_srcb | output | RW (5) | Second source register |
| out_dst | output | RW (5) | Destination register |
| out_pc | output | AW (32) | First instruction address |
| out_pc2 | output | AW (32) | Second instruction address (equal to out_pc unless fused) |
| out_fused | output | 1 | Record is a fused pair |

## Verification
A wrong hold bit shows up at the ports at once. It causes either a missing issue record in the cycle after a move (an instruction is lost) or a spurious extra move record (a duplicate), and the per-handshake comparison flags this within one transfer. A wrong match or operand selection shows up as a bad `out_srcb`, `out_dst` or flag on the very record that was fused. Self-referencing arithmetic and destination mismatches are driven on purpose so that these errors are not masked. Backpressure bugs show up as a reordering or dropped record later in the random stream. The final queue-empty check catches any record that never left.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  typedef enum logic [1:0] {
    K_OTHER = 2'd0,
    K_MOVE  = 2'd1,
    K_ARITH = 2'd2,
    K_FUSED = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_HELD  = 2'd1,
    SEL_FUSED = 2'd2
  } sel_t;
endpackage

// File: rtl/fuse_match.sv
module fuse_match
  import fuse_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          hold_v,
  input  logic [RW-1:0] hold_rd,
  input  logic          in_valid,
  input  kind_t         in_kind,
  input  logic [RW-1:0] in_rd,
  output logic          fuse
);
  logic kind_ok;
  logic dst_eq;

  always_comb begin
    kind_ok = (in_kind == K_ARITH);
    dst_eq  = (in_rd == hold_rd);
    fuse    = hold_v && in_valid && kind_ok && dst_eq;
  end
endmodule

// File: rtl/fuse_hold_ctrl.sv
module fuse_hold_ctrl
  import fuse_pkg::*;
#(
  parameter int RW = 5,
  parameter int FW = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  input  kind_t         in_kind,
  input  logic [FW-1:0] in_func,
  input  logic [RW-1:0] in_rs,
  input  logic [RW-1:0] in_rd,
  input  logic [AW-1:0] in_pc,
  input  logic          out_ready,
  input  logic          fuse,
  output logic          in_ready,
  output logic          out_valid,
  output sel_t          sel,
  output logic          hold_v,
  output logic [FW-1:0] hold_func,
  output logic [RW-1:0] hold_rs,
  output logic [RW-1:0] hold_rd,
  output logic [AW-1:0] hold_pc
);
  logic hold_v_nxt;
  logic load;
  logic in_is_move;

  assign in_is_move = in_valid && (in_kind == K_MOVE);

  // next-state and handshake decisions
  always_comb begin
    hold_v_nxt = hold_v;
    load       = 1'b0;
    in_ready   = 1'b0;
    out_valid  = 1'b0;
    sel        = SEL_PASS;
    if (flush) begin
      in_ready   = 1'b1;
      hold_v_nxt = 1'b0;
    end else if (hold_v) begin
      out_valid = 1'b1;
      if (fuse) begin
        sel      = SEL_FUSED;
        in_ready = out_ready;
        if (out_ready) hold_v_nxt = 1'b0;
      end else begin
        sel = SEL_HELD;
        if (out_ready) begin
          if (in_is_move) begin
            in_ready = 1'b1;
            load     = 1'b1;
          end else begin
            hold_v_nxt = 1'b0;
          end
        end
      end
    end else if (in_is_move) begin
      in_ready = 1'b1;
      load     = 1'b1;
    end else begin
      out_valid = in_valid;
      in_ready  = out_ready;
    end
    if (load) hold_v_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_v <= 1'b0;
    else        hold_v <= hold_v_nxt;
  end

  // payload registers: enable only, no reset needed
  always_ff @(posedge clk) begin
    if (load) begin
      hold_func <= in_func;
      hold_rs   <= in_rs;
      hold_rd   <= in_rd;
      hold_pc   <= in_pc;
    end
  end
endmodule

// File: rtl/fuse_operands.sv
module fuse_operands
  import fuse_pkg::*;
#(
  parameter int RW = 5,
  parameter int FW = 4,
  parameter int AW = 32
) (
  input  sel_t          sel,
  input  kind_t         in_kind,
  input  logic [FW-1:0] in_func,
  input  logic [RW-1:0] in_rs,
  input  logic [RW-1:0] in_rd,
  input  logic [AW-1:0] in_pc,
  input  logic [FW-1:0] hold_func,
  input  logic [RW-1:0] hold_rs,
  input  logic [RW-1:0] hold_rd,
  input  logic [AW-1:0] hold_pc,
  output kind_t         o_kind,
  output logic [FW-1:0] o_func,
  output logic [RW-1:0] o_srca,
  output logic [RW-1:0] o_srcb,
  output logic [RW-1:0] o_dst,
  output logic [AW-1:0] o_pc,
  output logic [AW-1:0] o_pc2,
  output logic          o_fused
);
  logic [RW-1:0] second_src;

  // the arithmetic's other source may also name the move destination
  assign second_src = (in_rs == hold_rd) ? hold_rs : in_rs;

  always_comb begin
    o_kind  = in_kind;
    o_func  = in_func;
    o_srca  = in_rd;
    o_srcb  = in_rs;
    o_dst   = in_rd;
    o_pc    = in_pc;
    o_pc2   = in_pc;
    o_fused = 1'b0;
    case (sel)
      SEL_HELD: begin
        o_kind = K_MOVE;
        o_func = hold_func;
        o_srca = hold_rd;
        o_srcb = hold_rs;
        o_dst  = hold_rd;
        o_pc   = hold_pc;
        o_pc2  = hold_pc;
      end
      SEL_FUSED: begin
        o_kind  = K_FUSED;
        o_srca  = hold_rs;
        o_srcb  = second_src;
        o_dst   = hold_rd;
        o_pc    = hold_pc;
        o_fused = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mov_alu_fuse.sv
module mov_alu_fuse
  import fuse_pkg::*;
#(
  parameter int RW = 5,
  parameter int FW = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic [FW-1:0] in_func,
  input  logic [RW-1:0] in_rs,
  input  logic [RW-1:0] in_rd,
  input  logic [AW-1:0] in_pc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [FW-1:0] out_func,
  output logic [RW-1:0] out_srca,
  output logic [RW-1:0] out_srcb,
  output logic [RW-1:0] out_dst,
  output logic [AW-1:0] out_pc,
  output logic [AW-1:0] out_pc2,
  output logic          out_fused
);
  kind_t         kind_in;
  kind_t         kind_out;
  sel_t          sel;
  logic          fuse;
  logic          hold_v;
  logic [FW-1:0] hold_func;
  logic [RW-1:0] hold_rs;
  logic [RW-1:0] hold_rd;
  logic [AW-1:0] hold_pc;

  assign kind_in  = kind_t'(in_kind);
  assign out_kind = kind_out;

  fuse_match #(.RW(RW)) u_match (
    .hold_v  (hold_v),
    .hold_rd (hold_rd),
    .in_valid(in_valid),
    .in_kind (kind_in),
    .in_rd   (in_rd),
    .fuse    (fuse)
  );

  fuse_hold_ctrl #(.RW(RW), .FW(FW), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_valid (in_valid),
    .in_kind  (kind_in),
    .in_func  (in_func),
    .in_rs    (in_rs),
    .in_rd    (in_rd),
    .in_pc    (in_pc),
    .out_ready(out_ready),
    .fuse     (fuse),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .sel      (sel),
    .hold_v   (hold_v),
    .hold_func(hold_func),
    .hold_rs  (hold_rs),
    .hold_rd  (hold_rd),
    .hold_pc  (hold_pc)
  );

  fuse_operands #(.RW(RW), .FW(FW), .AW(AW)) u_ops (
    .sel      (sel),
    .in_kind  (kind_in),
    .in_func  (in_func),
    .in_rs    (in_rs),
    .in_rd    (in_rd),
    .in_pc    (in_pc),
    .hold_func(hold_func),
    .hold_rs  (hold_rs),
    .hold_rd  (hold_rd),
    .hold_pc  (hold_pc),
    .o_kind   (kind_out),
    .o_func   (out_func),
    .o_srca   (out_srca),
    .o_srcb   (out_srcb),
    .o_dst    (out_dst),
    .o_pc     (out_pc),
    .o_pc2    (out_pc2),
    .o_fused  (out_fused)
  );
endmodule

// File: rtl/mov_alu_fuse_chk.sv
module mov_alu_fuse_chk
  import fuse_pkg::*;
#(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_kind,
  input logic [RW-1:0] in_rd,
  input logic          out_valid,
  input logic          out_ready,
  input logic [RW-1:0] out_dst,
  input logic          out_fused
);
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!out_valid && in_ready)); // R9

  AST_MOVE_ISSUES_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind == 2'd1 && !flush) |=> (out_valid || flush)); // R3

  AST_FUSE_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused) |-> (in_valid && in_kind == 2'd2 && in_rd == out_dst)); // R4

  AST_STALL_KEEPS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid || flush)); // R10

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind != 2'd1 && !out_ready && !flush) |-> !in_ready); // R10
endmodule

bind mov_alu_fuse mov_alu_fuse_chk #(.RW(RW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_kind  (in_kind),
  .in_rd    (in_rd),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_dst  (out_dst),
  .out_fused(out_fused)
);

// File: tb/mov_alu_fuse_tb.sv
module mov_alu_fuse_tb;
  localparam int RW = 5;
  localparam int FW = 4;
  localparam int AW = 32;
  localparam int N  = 300;

  typedef struct packed {
    logic [1:0]    k;
    logic [FW-1:0] f;
    logic [RW-1:0] a;
    logic [RW-1:0] b;
    logic [RW-1:0] d;
    logic [AW-1:0] p;
    logic [AW-1:0] p2;
    logic          fu;
  } rec_t;

  logic clk, rst_n, flush, in_valid, in_ready, out_valid, out_ready, out_fused;
  logic [1:0] in_kind, out_kind;
  logic [FW-1:0] in_func, out_func;
  logic [RW-1:0] in_rs, in_rd, out_srca, out_srcb, out_dst;
  logic [AW-1:0] in_pc, out_pc, out_pc2;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_en = 0;
  rec_t exp_q[$];

  logic [1:0]    pk [N];
  logic [FW-1:0] pf [N];
  logic [RW-1:0] ps [N];
  logic [RW-1:0] pd [N];

  mov_alu_fuse #(.RW(RW), .FW(FW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_func(in_func),
    .in_rs(in_rs), .in_rd(in_rd), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_func(out_func),
    .out_srca(out_srca), .out_srcb(out_srcb), .out_dst(out_dst),
    .out_pc(out_pc), .out_pc2(out_pc2), .out_fused(out_fused)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic rec_t cur_out();
    return '{k: out_kind, f: out_func, a: out_srca, b: out_srcb, d: out_dst,
             p: out_pc, p2: out_pc2, fu: out_fused};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rec(input string req, input rec_t act, input rec_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic [FW-1:0] f,
                       input logic [RW-1:0] rs, input logic [RW-1:0] rd, input logic [AW-1:0] pc);
    @(posedge clk); #1;
    in_valid = v; in_kind = k; in_func = f; in_rs = rs; in_rd = rd; in_pc = pc;
    @(negedge clk);
  endtask

  // per-transfer comparison against the program-order model (R2 R4 R5 R6 R7 R10)
  always @(negedge clk) begin
    if (mon_en && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual=extra record pc %0h expected=none", out_pc);
      end else begin
        chk_rec(exp_q[0].fu ? "R4 R5 R6 fused record" : "R2 R7 single record",
                cur_out(), exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_kind = 2'd0; in_func = '0;
    in_rs = '0; in_rd = '0; in_pc = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);

    // R2 pass-through of arithmetic
    drive(1, 2'd2, 4'd3, 5'd2, 5'd7, 32'h10);
    chk_rec("R2 pass", cur_out(), '{k:2'd2, f:4'd3, a:5'd7, b:5'd2, d:5'd7, p:32'h10, p2:32'h10, fu:1'b0});
    chk("R2 in_ready", 64'(in_ready && out_valid), 64'd1);

    // R3 capture, then R4 R5 R6 fusion with self-referencing second source
    drive(1, 2'd1, 4'd0, 5'd3, 5'd5, 32'h20);
    chk("R3 no output on capture", 64'(out_valid), 64'd0);
    drive(1, 2'd2, 4'd1, 5'd5, 5'd5, 32'h22);
    chk_rec("R4 R5 R6 fused", cur_out(), '{k:2'd3, f:4'd1, a:5'd3, b:5'd3, d:5'd5, p:32'h20, p2:32'h22, fu:1'b1});
    chk("R4 partner consumed", 64'(in_ready), 64'd1);

    // R5 second source different from destination stays
    drive(1, 2'd1, 4'd0, 5'd8, 5'd9, 32'h24);
    drive(1, 2'd2, 4'd6, 5'd4, 5'd9, 32'h26);
    chk_rec("R5 other source kept", cur_out(), '{k:2'd3, f:4'd6, a:5'd8, b:5'd4, d:5'd9, p:32'h24, p2:32'h26, fu:1'b1});

    // R7 destination mismatch
    drive(1, 2'd1, 4'd0, 5'd1, 5'd4, 32'h30);
    drive(1, 2'd2, 4'd2, 5'd2, 5'd6, 32'h32);
    chk_rec("R7 move alone", cur_out(), '{k:2'd1, f:4'd0, a:5'd4, b:5'd1, d:5'd4, p:32'h30, p2:32'h30, fu:1'b0});
    chk("R7 successor held back", 64'(in_ready), 64'd0);
    drive(1, 2'd2, 4'd2, 5'd2, 5'd6, 32'h32);
    chk_rec("R7 successor next", cur_out(), '{k:2'd2, f:4'd2, a:5'd6, b:5'd2, d:5'd6, p:32'h32, p2:32'h32, fu:1'b0});

    // R8 no successor
    drive(1, 2'd1, 4'd0, 5'd9, 5'd10, 32'h40);
    drive(0, 2'd0, 4'd0, 5'd0, 5'd0, 32'h0);
    chk_rec("R8 move alone on gap", cur_out(), '{k:2'd1, f:4'd0, a:5'd10, b:5'd9, d:5'd10, p:32'h40, p2:32'h40, fu:1'b0});
    chk("R8 valid", 64'(out_valid), 64'd1);
    drive(0, 2'd0, 4'd0, 5'd0, 5'd0, 32'h0);
    chk("R8 idle afterwards", 64'(out_valid), 64'd0);

    // R9 flush drops held move and partner
    drive(1, 2'd1, 4'd0, 5'd2, 5'd3, 32'h50);
    @(posedge clk); #1;
    flush = 1'b1; in_valid = 1'b1; in_kind = 2'd2; in_rs = 5'd1; in_rd = 5'd3; in_pc = 32'h52;
    @(negedge clk);
    chk("R9 quiet during flush", 64'({out_valid, in_ready}), 64'b01);
    @(posedge clk); #1; flush = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 held move discarded", 64'(out_valid), 64'd0);

    // R10 backpressure on pass-through
    @(posedge clk); #1; out_ready = 1'b0;
    in_valid = 1'b1; in_kind = 2'd2; in_func = 4'd5; in_rs = 5'd1; in_rd = 5'd2; in_pc = 32'h60;
    @(negedge clk);
    chk("R10 stalled input not taken", 64'({out_valid, in_ready}), 64'b10);
    @(posedge clk); @(negedge clk);
    chk("R10 output held", 64'(out_pc), 64'h60);
    @(posedge clk); #1; out_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", 64'({out_valid, in_ready}), 64'b11);
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    chk("R10 no duplicate", 64'(out_valid), 64'd0);

    // random stream with backpressure, compared on every transfer
    for (int i = 0; i < N; i++) begin
      pk[i] = 2'($urandom % 3);
      pf[i] = FW'($urandom);
      ps[i] = RW'($urandom % 4);
      pd[i] = RW'($urandom % 4);
    end
    for (int i = 0; i < N; i++) begin
      if (pk[i] == 2'd1 && i + 1 < N && pk[i+1] == 2'd2 && pd[i+1] == pd[i]) begin
        exp_q.push_back('{k:2'd3, f:pf[i+1], a:ps[i],
                          b:(ps[i+1] == pd[i]) ? ps[i] : ps[i+1], d:pd[i],
                          p:AW'(32'h1000 + 2*i), p2:AW'(32'h1000 + 2*(i+1)), fu:1'b1});
        i++;
      end else begin
        exp_q.push_back('{k:pk[i], f:pf[i], a:pd[i], b:ps[i], d:pd[i],
                          p:AW'(32'h1000 + 2*i), p2:AW'(32'h1000 + 2*i), fu:1'b0});
      end
    end
    mon_en = 1'b1;
    begin
      int idx = 0;
      int guard = 0;
      while ((idx < N || exp_q.size() != 0) && guard < 20000) begin
        bit acc;
        @(posedge clk); #1;
        out_ready = ($urandom % 10) < 7;
        if (idx < N) begin
          in_valid = 1'b1; in_kind = pk[idx]; in_func = pf[idx];
          in_rs = ps[idx]; in_rd = pd[idx]; in_pc = AW'(32'h1000 + 2*idx);
        end else begin
          in_valid = 1'b0;
        end
        @(negedge clk);
        acc = in_valid && in_ready;
        if (acc) idx++;
        guard++;
      end
    end
    @(posedge clk); #1; mon_en = 1'b0;
    chk("R10 every record issued", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule